// File: doc/BRIEF.md
# Link Source Interface Controller

This block is the sending end of a one-way point-to-point data link. A front-end user writes 32-bit words, each tagged with a control/data flag, on the user clock. The block holds them in a small first-in first-out buffer and hands them, oldest first, to a serializer-side word port with a valid/ready handshake. An early-warning full flag goes back to the user. It rises while room for two more words still remains, so a user that reacts late can finish two writes without losing data.

A link state machine owns the rest. It has four states:

- `ST_WAIT_REMOTE`: the link is down and the block waits for the far end.
- `ST_LINK_UP`: words are forwarded.
- `ST_TEST`: test mode.
- `ST_LINK_FAIL`: a latched failure.

It has seven transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| T_UP | `ST_WAIT_REMOTE` | `ST_LINK_UP` | remote ready and not in reset |
| T_FAIL | `ST_LINK_UP` or `ST_TEST` | `ST_LINK_FAIL` | `fail_in` |
| T_DROP | `ST_LINK_UP` or `ST_TEST` | `ST_WAIT_REMOTE` | `remote_reset` |
| T_TEST_IN | `ST_LINK_UP` | `ST_TEST` | `test_req` |
| T_TEST_OUT | `ST_TEST` | `ST_LINK_UP` | `test_req` low |

Priority is T_FAIL over T_DROP over the test transitions. `ST_LINK_FAIL` has no exit; only a reset cycle leaves it. Any entry into or exit from `ST_TEST` empties the buffer and clears the overflow error.

The reset input is asynchronous. It is asserted at once and released through a two-stage synchronizer. While reset is active, the block tells the far end so through `local_reset_out`.

Top module: `lsc_ctrl`

## Requirements
- R1: `almost_full` is 1 exactly when the buffer (16 entries) holds 14 or more words, that is, when 2 or fewer entries are free.
- R2: Every accepted word leaves on `tx_data`/`tx_ctrl` in write order with its control flag. This includes the two words written after `almost_full` rises.
- R3: A write while 16 words are held and no word leaves in that cycle is dropped. It sets `ovf_err`, which then stays 1.
- R4: `fail_in` sampled high in `ST_LINK_UP` or `ST_TEST` sets `link_down` after that edge. `link_down` then stays 1, whatever `fail_in` and the remote inputs do, until a reset cycle.
- R5: While `link_down` is 1, `tx_valid` is 0 even when words are buffered.
- R6: Reset timing:
  - `rst_n` low sets `local_reset_out` and `link_down` to 1 and empties the buffer without waiting for a clock.
  - After `rst_n` rises, `local_reset_out` falls on the second rising clock edge.
  - `link_down` falls on the first edge after that at which `remote_ready` is 1 and `remote_reset` is 0.
- R7: `remote_reset` high while up or in test sets `link_down` after the next edge. This drop is not latched: the link comes back when the remote is ready again, and buffered words are kept.
- R8: `ret_lines` is 0 whenever `link_down` is 1, including after reset. In `ST_LINK_UP` and `ST_TEST` it follows `ret_in`.
- R9: On the edge that enters or leaves `ST_TEST`, the buffer is emptied and `ovf_err` is cleared. A write in that same cycle is discarded.
- R10: In test mode, writes are still stored and `almost_full` and R3 still apply, but `tx_valid` stays 0.
- R11: `test_req` has no effect unless the link is up: in `ST_WAIT_REMOTE` and `ST_LINK_FAIL`, `test_mode` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the user |
| wr_data | input | 32 | Data word to send |
| wr_ctrl | input | 1 | Control (1) / data (0) flag of the word |
| almost_full | output | 1 | Early full warning, two words of slack |
| ovf_err | output | 1 | Sticky overflow error |
| test_req | input | 1 | Test mode request |
| test_mode | output | 1 | Test mode active |
| fail_in | input | 1 | Link failure indication |
| link_down | output | 1 | Link not usable |
| ret_lines | output | 4 | Return lines from the far end, 0 while down |
| tx_valid | output | 1 | Word on tx_data/tx_ctrl is valid |
| tx_ready | input | 1 | Serializer side takes the word |
| tx_data | output | 32 | Outgoing data word |
| tx_ctrl | output | 1 | Outgoing control flag |
| remote_ready | input | 1 | Far end ready |
| remote_reset | input | 1 | Far end is in reset |
| ret_in | input | 4 | Return lines from the far end |
| local_reset_out | output | 1 | Tells the far end this end is in reset |

## Verification
The hardest situation to reach from the ports is the overflow boundary inside test mode. The buffer must first be filled past the slack threshold while the output is blocked by the mode itself, not by `tx_ready`. The error must then be shown to vanish on the exit edge. The bench gets there by first setting `ovf_err` in normal operation, then entering test mode with words buffered, so that both the flush and the error clear are visible at entry. It then refills the buffer word by word to 17 writes with `tx_ready` held high, and finally leaves test mode. The sticky failure is reached by pulsing `fail_in` once. The bench then checks that a ready remote and a test request cannot revive the link before a mid-cycle asynchronous reset does.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_REMOTE = 2'd0,
        ST_LINK_UP     = 2'd1,
        ST_TEST        = 2'd2,
        ST_LINK_FAIL   = 2'd3
    } link_state_t;

    localparam int RET_W = 4;

endpackage

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = chain[STAGES-1];

endmodule

// File: rtl/lsc_fifo.sv
module lsc_fifo #(
    parameter int DW    = 33,
    parameter int DEPTH = 16,
    parameter int SLACK = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           wr_en,
    input  logic [DW-1:0]                  wr_word,
    input  logic                           rd_en,
    output logic [DW-1:0]                  rd_word,
    output logic                           empty,
    output logic                           almost_full,
    output logic [$clog2(DEPTH+1)-1:0]     fill,
    output logic                           pop,
    output logic                           overflow_err
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] WARN_CNT = CW'(DEPTH - SLACK);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push;
    logic          overflow;

    always_comb begin
        pop      = rd_en && (fill != '0) && !flush;
        push     = wr_en && !flush && ((fill != FULL_CNT) || pop);
        overflow = wr_en && !flush && (fill == FULL_CNT) && !pop;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow_err <= 1'b0;
        end else if (flush) begin
            overflow_err <= 1'b0;
        end else if (overflow) begin
            overflow_err <= 1'b1;
        end
    end

    assign rd_word     = mem[rd_ptr];
    assign empty       = (fill == '0);
    assign almost_full = (fill >= WARN_CNT);

endmodule

// File: rtl/lsc_link_fsm.sv
module lsc_link_fsm
    import lsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic remote_ready,
    input  logic remote_reset,
    input  logic fail_in,
    input  logic test_req,
    output logic link_down,
    output logic link_up,
    output logic test_mode,
    output logic link_fail,
    output logic flush
);

    link_state_t state;
    link_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_REMOTE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_REMOTE: begin
                if (remote_ready && !remote_reset) state_nxt = ST_LINK_UP;
            end
            ST_LINK_UP: begin
                if (fail_in)           state_nxt = ST_LINK_FAIL;
                else if (remote_reset) state_nxt = ST_WAIT_REMOTE;
                else if (test_req)     state_nxt = ST_TEST;
            end
            ST_TEST: begin
                if (fail_in)           state_nxt = ST_LINK_FAIL;
                else if (remote_reset) state_nxt = ST_WAIT_REMOTE;
                else if (!test_req)    state_nxt = ST_LINK_UP;
            end
            ST_LINK_FAIL: begin
                state_nxt = ST_LINK_FAIL;
            end
            default: state_nxt = ST_WAIT_REMOTE;
        endcase
    end

    // Outputs
    always_comb begin
        link_down = 1'b1;
        link_up   = 1'b0;
        test_mode = 1'b0;
        link_fail = 1'b0;
        unique case (state)
            ST_WAIT_REMOTE: link_down = 1'b1;
            ST_LINK_UP: begin
                link_down = 1'b0;
                link_up   = 1'b1;
            end
            ST_TEST: begin
                link_down = 1'b0;
                test_mode = 1'b1;
            end
            ST_LINK_FAIL: link_fail = 1'b1;
            default: link_down = 1'b1;
        endcase
        flush = (state == ST_TEST) != (state_nxt == ST_TEST);
    end

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 16,
    parameter int SLACK      = 2,
    parameter int RET_W      = lsc_pkg::RET_W,
    parameter int RST_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ctrl,
    output logic              almost_full,
    output logic              ovf_err,
    input  logic              test_req,
    output logic              test_mode,
    input  logic              fail_in,
    output logic              link_down,
    output logic [RET_W-1:0]  ret_lines,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_ctrl,
    input  logic              remote_ready,
    input  logic              remote_reset,
    input  logic [RET_W-1:0]  ret_in,
    output logic              local_reset_out
);

    localparam int WORD_W = DATA_W + 1;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              rst_sync_n;
    logic              link_up;
    logic              link_fail;
    logic              flush;
    logic              pop;
    logic              fifo_empty;
    logic [CW-1:0]     fill;
    logic [WORD_W-1:0] head_word;

    lsc_rst_sync #(
        .STAGES (RST_STAGES)
    ) u_rst_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    lsc_link_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_sync_n),
        .remote_ready (remote_ready),
        .remote_reset (remote_reset),
        .fail_in      (fail_in),
        .test_req     (test_req),
        .link_down    (link_down),
        .link_up      (link_up),
        .test_mode    (test_mode),
        .link_fail    (link_fail),
        .flush        (flush)
    );

    lsc_fifo #(
        .DW    (WORD_W),
        .DEPTH (DEPTH),
        .SLACK (SLACK)
    ) u_fifo (
        .clk          (clk),
        .rst_n        (rst_sync_n),
        .flush        (flush),
        .wr_en        (wr_en),
        .wr_word      ({wr_ctrl, wr_data}),
        .rd_en        (tx_valid && tx_ready),
        .rd_word      (head_word),
        .empty        (fifo_empty),
        .almost_full  (almost_full),
        .fill         (fill),
        .pop          (pop),
        .overflow_err (ovf_err)
    );

    assign tx_valid        = link_up && !fifo_empty;
    assign tx_data         = head_word[DATA_W-1:0];
    assign tx_ctrl         = head_word[DATA_W];
    assign ret_lines       = link_down ? '0 : ret_in;
    assign local_reset_out = !rst_sync_n;

endmodule

// File: rtl/lsc_ctrl_chk.sv
module lsc_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int RET_W = 4,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_sync_n,
    input logic             wr_en,
    input logic             almost_full,
    input logic             ovf_err,
    input logic             test_mode,
    input logic             link_down,
    input logic             link_fail,
    input logic             tx_valid,
    input logic             remote_reset,
    input logic             pop,
    input logic             flush,
    input logic [CW-1:0]    fill,
    input logic [RET_W-1:0] ret_lines
);

    AST_SLACK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!almost_full && !ovf_err) |=> !ovf_err); // R1

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
        fill <= CW'(DEPTH)); // R2

    AST_OVF_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (wr_en && fill == CW'(DEPTH) && !pop && !flush) |=> ovf_err); // R3

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
        link_fail |=> (link_fail && link_down)); // R4

    AST_NO_TX_DOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
        link_down |-> !tx_valid); // R5

    AST_REMOTE_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
        remote_reset |=> link_down); // R7

    AST_RET_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
        link_down |-> (ret_lines == '0)); // R8

    AST_TEST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
        ($rose(test_mode) || $fell(test_mode)) |-> (fill == '0 && !ovf_err)); // R9

endmodule

bind lsc_ctrl lsc_ctrl_chk #(
    .DEPTH (DEPTH),
    .RET_W (RET_W),
    .CW    (CW)
) u_chk (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .wr_en        (wr_en),
    .almost_full  (almost_full),
    .ovf_err      (ovf_err),
    .test_mode    (test_mode),
    .link_down    (link_down),
    .link_fail    (link_fail),
    .tx_valid     (tx_valid),
    .remote_reset (remote_reset),
    .pop          (pop),
    .flush        (flush),
    .fill         (fill),
    .ret_lines    (ret_lines)
);

// File: tb/lsc_ctrl_tb.sv
`timescale 1ns/1ps
module lsc_ctrl_tb;

    localparam int DEPTH = 16;
    localparam int SLACK = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        wr_ctrl;
    logic        almost_full;
    logic        ovf_err;
    logic        test_req;
    logic        test_mode;
    logic        fail_in;
    logic        link_down;
    logic [3:0]  ret_lines;
    logic        tx_valid;
    logic        tx_ready;
    logic [31:0] tx_data;
    logic        tx_ctrl;
    logic        remote_ready;
    logic        remote_reset;
    logic [3:0]  ret_in;
    logic        local_reset_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lsc_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .wr_ctrl         (wr_ctrl),
        .almost_full     (almost_full),
        .ovf_err         (ovf_err),
        .test_req        (test_req),
        .test_mode       (test_mode),
        .fail_in         (fail_in),
        .link_down       (link_down),
        .ret_lines       (ret_lines),
        .tx_valid        (tx_valid),
        .tx_ready        (tx_ready),
        .tx_data         (tx_data),
        .tx_ctrl         (tx_ctrl),
        .remote_ready    (remote_ready),
        .remote_reset    (remote_reset),
        .ret_in          (ret_in),
        .local_reset_out (local_reset_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] d, input logic c);
        wr_en   = 1'b1;
        wr_data = d;
        wr_ctrl = c;
        step();
        wr_en   = 1'b0;
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_ctrl = 1'b0;
        test_req = 1'b0; fail_in = 1'b0; tx_ready = 1'b0;
        remote_ready = 1'b0; remote_reset = 1'b0; ret_in = 4'hF;
        repeat (3) step();

        // R6 / R8 reset state
        chk("R6 reset local_reset_out", local_reset_out, 1);
        chk("R6 reset link_down", link_down, 1);
        chk("R5 reset tx_valid", tx_valid, 0);
        chk("R1 reset almost_full", almost_full, 0);
        chk("R3 reset ovf_err", ovf_err, 0);
        chk("R8 reset ret_lines", ret_lines, 0);

        // R6 release takes two edges
        rst_n = 1'b1;
        step();
        chk("R6 release edge1", local_reset_out, 1);
        step();
        chk("R6 release edge2", local_reset_out, 0);
        repeat (3) step();
        chk("R6 waits for remote", link_down, 1);

        // R11 test request ignored while waiting
        test_req = 1'b1;
        step();
        chk("R11 test while waiting", test_mode, 0);
        test_req = 1'b0;

        remote_ready = 1'b1;
        ret_in = 4'h5;
        step();
        chk("R6 link up after remote ready", link_down, 0);
        chk("R8 ret_lines follow", ret_lines, 4'h5);

        // R1 sweep of the fill level, R2 slack kept, R3 overflow
        for (int k = 1; k <= DEPTH; k++) begin
            put(32'hA000_0000 + k, k[0]);
            chk("R1 almost_full vs level", almost_full, (k >= DEPTH - SLACK) ? 1 : 0);
        end
        chk("R3 no error at capacity", ovf_err, 0);
        put(32'hDEAD_BEEF, 1'b1);
        chk("R3 overflow sets error", ovf_err, 1);
        tx_ready = 1'b1;
        for (int k = 1; k <= DEPTH; k++) begin
            chk("R2 tx_valid while draining", tx_valid, 1);
            chk("R2 data order", tx_data, 32'hA000_0000 + k);
            chk("R2 ctrl flag", tx_ctrl, k[0]);
            step();
        end
        chk("R2 empty after drain", tx_valid, 0);
        chk("R3 error sticky", ovf_err, 1);

        // R9 entering test clears buffer and error
        tx_ready = 1'b0;
        for (int k = 0; k < 5; k++) put(32'h1000 + k, 1'b0);
        test_req = 1'b1;
        step();
        chk("R9 test entered", test_mode, 1);
        chk("R9 error cleared at entry", ovf_err, 0);
        tx_ready = 1'b1;
        chk("R9 buffer flushed at entry", tx_valid, 0);

        // R10 writes in test mode
        for (int k = 1; k <= DEPTH; k++) begin
            put(32'h2000 + k, 1'b1);
            chk("R10 almost_full in test", almost_full, (k >= DEPTH - SLACK) ? 1 : 0);
            chk("R10 nothing forwarded", tx_valid, 0);
        end
        chk("R10 no error at capacity", ovf_err, 0);
        put(32'h2FFF, 1'b0);
        chk("R10 overflow in test", ovf_err, 1);

        // R9 leaving test clears buffer and error
        test_req = 1'b0;
        step();
        chk("R9 test left", test_mode, 0);
        chk("R9 error cleared at exit", ovf_err, 0);
        chk("R9 buffer flushed at exit", tx_valid, 0);
        chk("R9 almost_full after exit", almost_full, 0);

        // R7 remote reset drops link, not latched, data kept
        tx_ready = 1'b0;
        put(32'h3001, 1'b1);
        put(32'h3002, 1'b0);
        remote_reset = 1'b1;
        step();
        chk("R7 link_down on remote reset", link_down, 1);
        chk("R5 no tx while down", tx_valid, 0);
        chk("R8 ret_lines low while down", ret_lines, 0);
        remote_reset = 1'b0;
        step();
        chk("R7 link returns", link_down, 0);
        chk("R7 data kept valid", tx_valid, 1);
        chk("R7 data kept head", tx_data, 32'h3001);

        // R4 sticky failure, R5 no forwarding
        fail_in = 1'b1;
        step();
        fail_in = 1'b0;
        tx_ready = 1'b1;
        chk("R4 failure sets link_down", link_down, 1);
        repeat (4) step();
        chk("R4 link_down stays latched", link_down, 1);
        chk("R5 buffered words not sent", tx_valid, 0);
        test_req = 1'b1;
        step();
        chk("R11 test while failed", test_mode, 0);
        test_req = 1'b0;

        // R6 asynchronous reset mid-cycle clears the failure
        rst_n = 1'b0;
        #1;
        chk("R6 async local_reset_out", local_reset_out, 1);
        step();
        rst_n = 1'b1;
        step();
        step();
        chk("R6 sync release", local_reset_out, 0);
        step();
        chk("R4 cleared by reset cycle", link_down, 0);
        chk("R6 buffer emptied by reset", tx_valid, 0);
        chk("R8 ret_lines after reset", ret_lines, 4'h5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule